// File: doc/BRIEF.md
# Dual Page-Size Translation Lookaside Buffer

This block caches address translations for two page sizes at once. Small pages cover 4 KB and large pages cover 4 MB. A lookup presents a 20-bit virtual page number, which is virtual address bits 31:12. Both storage arrays are searched in the same cycle. The block returns a hit flag, the physical page number (physical bits 31:12), the cached attribute bits, and which page size produced the hit. The lookup result is combinational from the stored state.

A page walker installs entries through a fill port. The fill carries a page-size select, the virtual page number, the physical page number and the attributes. Small pages live in a 4-way array of 16 sets. Large pages live in a 4-way array of 2 sets.

Each set picks its victim with a 3-bit tree pseudo-LRU. Empty ways are always used before any valid way is replaced. Two flush commands are provided. One drops every entry. The other drops only the entries whose global attribute bit is clear.

Top module: `dual_tlb`

## Requirements
- R1: After reset every entry is invalid, so any lookup misses (`lkp_hit_o`=0).
- R2: A small-page entry is found using set `vpn[3:0]` and tag `vpn[19:4]`. On a hit it returns the stored 20-bit page number and 6-bit attributes unchanged, with `lkp_big_o`=0. The attribute bits are, MSB to LSB: global, dirty, cache-disable, write-through, user, writable.
- R3: A large-page entry is found using set `vpn[10]` and tag `vpn[19:11]`. On a hit it returns `{stored_pfn[19:10], vpn[9:0]}` with `lkp_big_o`=1. Bits 9:0 of the fill page number are ignored for large pages.
- R4: When both arrays hit, the small-page result is returned.
- R5: Every set holds four distinct translations. All 64 small and 8 large entries can be resident at once.
- R6: A fill into a set uses the lowest empty way first. After four fills and no lookups, a fifth fill into that set evicts the first entry filled.
- R7: A lookup hit marks its way as recently used. After ways 0..3 are filled and way 0 is then hit, the next fill evicts way 2.
- R8: A fill whose tag matches a valid entry in the same set overwrites that entry. A following lookup returns the newest page number and attributes.
- R9: A flush-all pulse invalidates every entry in both arrays.
- R10: A non-global flush pulse invalidates exactly the entries whose global bit is 0. Global entries keep hitting.
- R11: A flush and a fill in the same cycle apply the flush first. The newly filled entry is valid afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lkp_valid_i | input | 1 | Lookup request |
| lkp_vpn_i | input | 20 | Virtual page number to translate |
| lkp_hit_o | output | 1 | Translation found |
| lkp_big_o | output | 1 | Hit came from the large-page array |
| lkp_pfn_o | output | 20 | Physical page number |
| lkp_attr_o | output | 6 | Cached attribute bits |
| fill_valid_i | input | 1 | Install a translation |
| fill_big_i | input | 1 | Fill is a 4 MB page |
| fill_vpn_i | input | 20 | Virtual page number of the fill |
| fill_pfn_i | input | 20 | Physical page number of the fill |
| fill_attr_i | input | 6 | Attribute bits of the fill |
| flush_all_i | input | 1 | Invalidate all entries |
| flush_ng_i | input | 1 | Invalidate non-global entries |

## Verification
Flushes and fills can land in the same cycle. This is provoked by pulsing a flush together with a fill of a different page. The result is judged by looking up both pages afterwards: the page resident beforehand must miss and the newly filled page must hit. A lookup hit can also share a cycle with a fill into the same set. The pseudo-LRU ordering tests drive lookups and fills into one set in sequence, and they check which entry is evicted.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned WAYS    = 4;
  localparam int unsigned WAY_W   = 2;
  localparam int unsigned ATTR_W  = 6;
  localparam int unsigned GLB_BIT = 5;  // attr: {glb, dirty, cd, wt, user, wr}
  typedef logic [WAY_W-1:0]  way_t;
  typedef logic [ATTR_W-1:0] attr_t;
endpackage

// File: rtl/tlb_plru.sv
module tlb_plru
  import tlb_pkg::*;
#(
  parameter int unsigned SETS  = 16,
  localparam int unsigned SET_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [SET_W-1:0] touch_set_i,
  input  way_t             touch_way_i,
  input  logic             fill_i,
  input  logic [SET_W-1:0] fill_set_i,
  input  way_t             fill_way_i,
  input  logic [SET_W-1:0] vict_set_i,
  output way_t             vict_way_o
);
  // tree bit0: root (0 -> left pair), bit1: left pair, bit2: right pair
  logic [2:0] tree_q [SETS];

  function automatic logic [2:0] point_away(logic [2:0] t, way_t w);
    logic [2:0] n;
    n = t;
    if (!w[1]) begin
      n[0] = 1'b1;
      n[1] = ~w[0];
    end else begin
      n[0] = 1'b0;
      n[2] = ~w[0];
    end
    return n;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
    end else begin
      for (int s = 0; s < SETS; s++) begin
        if (fill_i && fill_set_i == SET_W'(s))
          tree_q[s] <= point_away(tree_q[s], fill_way_i);
        else if (touch_i && touch_set_i == SET_W'(s))
          tree_q[s] <= point_away(tree_q[s], touch_way_i);
      end
    end
  end

  logic [2:0] vt;
  assign vt         = tree_q[vict_set_i];
  assign vict_way_o = vt[0] ? {1'b1, vt[2]} : {1'b0, vt[1]};
endmodule

// File: rtl/tlb_array.sv
module tlb_array
  import tlb_pkg::*;
#(
  parameter int unsigned SETS  = 16,
  parameter int unsigned TAG_W = 16,
  parameter int unsigned PFN_W = 20,
  localparam int unsigned SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int unsigned IDX_W = SET_W + WAY_W,
  localparam int unsigned N     = SETS * WAYS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lkp_i,
  input  logic [SET_W-1:0] lkp_set_i,
  input  logic [TAG_W-1:0] lkp_tag_i,
  output logic             hit_o,
  output logic [PFN_W-1:0] hit_pfn_o,
  output attr_t            hit_attr_o,
  input  logic             fill_i,
  input  logic [SET_W-1:0] fill_set_i,
  input  logic [TAG_W-1:0] fill_tag_i,
  input  logic [PFN_W-1:0] fill_pfn_i,
  input  attr_t            fill_attr_i,
  input  logic             flush_all_i,
  input  logic             flush_ng_i
);
  logic [N-1:0]     valid_q;
  logic [N-1:0]     glob_v;
  logic [TAG_W-1:0] tag_q  [N];
  logic [PFN_W-1:0] pfn_q  [N];
  attr_t            attr_q [N];

  logic [WAYS-1:0] lkp_match, fill_match, fill_row_v;
  way_t            lkp_way, fill_way, vict_way;
  logic [IDX_W-1:0] fill_idx;

  for (genvar i = 0; i < N; i++) begin : g_glob
    assign glob_v[i] = attr_q[i][GLB_BIT];
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    localparam way_t WI = way_t'(w);
    assign lkp_match[w]  = valid_q[{lkp_set_i, WI}] && (tag_q[{lkp_set_i, WI}] == lkp_tag_i);
    assign fill_match[w] = valid_q[{fill_set_i, WI}] && (tag_q[{fill_set_i, WI}] == fill_tag_i);
    assign fill_row_v[w] = valid_q[{fill_set_i, WI}];
  end

  always_comb begin
    hit_pfn_o  = '0;
    hit_attr_o = '0;
    lkp_way    = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (lkp_match[w]) begin
        hit_pfn_o  = hit_pfn_o  | pfn_q[{lkp_set_i, way_t'(w)}];
        hit_attr_o = hit_attr_o | attr_q[{lkp_set_i, way_t'(w)}];
        lkp_way    = lkp_way    | way_t'(w);
      end
    end
  end
  assign hit_o = |lkp_match;

  // way choice: matching tag, else lowest empty, else pseudo-LRU victim
  always_comb begin
    fill_way = vict_way;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!fill_row_v[w]) fill_way = way_t'(w);
    for (int w = 0; w < WAYS; w++)
      if (fill_match[w]) fill_way = way_t'(w);
  end
  assign fill_idx = {fill_set_i, fill_way};

  tlb_plru #(.SETS(SETS)) u_plru (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .touch_i     (lkp_i && hit_o),
    .touch_set_i (lkp_set_i),
    .touch_way_i (lkp_way),
    .fill_i      (fill_i),
    .fill_set_i  (fill_set_i),
    .fill_way_i  (fill_way),
    .vict_set_i  (fill_set_i),
    .vict_way_o  (vict_way)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else begin
      if (flush_all_i)     valid_q <= '0;
      else if (flush_ng_i) valid_q <= valid_q & glob_v;
      if (fill_i)          valid_q[fill_idx] <= 1'b1;  // flush first, then fill
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_i) begin
      tag_q[fill_idx]  <= fill_tag_i;
      pfn_q[fill_idx]  <= fill_pfn_i;
      attr_q[fill_idx] <= fill_attr_i;
    end
  end

  a_r8_no_dup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lkp_match)) else $error("duplicate tag in set");

  a_r6_empty_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i && !(|fill_match) && !(&fill_row_v) |-> !fill_row_v[fill_way])
    else $error("valid way replaced while an empty way exists");

  a_r9_flush_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_all_i && !fill_i |=> valid_q == '0) else $error("entries survive flush-all");

  a_r10_keep_global: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_ng_i && !flush_all_i && !fill_i |=> valid_q == $past(valid_q & glob_v))
    else $error("non-global flush wrong");

  a_r11_fill_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i |=> valid_q[$past(fill_idx)]) else $error("filled entry not valid");
endmodule

// File: rtl/dual_tlb.sv
module dual_tlb
  import tlb_pkg::*;
#(
  parameter int unsigned VPN_W      = 20,
  parameter int unsigned SMALL_SETS = 16,
  parameter int unsigned BIG_SETS   = 2,
  parameter int unsigned BIG_OFF_W  = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lkp_valid_i,
  input  logic [VPN_W-1:0] lkp_vpn_i,
  output logic             lkp_hit_o,
  output logic             lkp_big_o,
  output logic [VPN_W-1:0] lkp_pfn_o,
  output logic [ATTR_W-1:0] lkp_attr_o,
  input  logic             fill_valid_i,
  input  logic             fill_big_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [VPN_W-1:0] fill_pfn_i,
  input  logic [ATTR_W-1:0] fill_attr_i,
  input  logic             flush_all_i,
  input  logic             flush_ng_i
);
  localparam int unsigned S_SET_W = $clog2(SMALL_SETS);
  localparam int unsigned S_TAG_W = VPN_W - S_SET_W;
  localparam int unsigned B_SET_W = $clog2(BIG_SETS);
  localparam int unsigned B_TAG_W = VPN_W - BIG_OFF_W - B_SET_W;
  localparam int unsigned B_PFN_W = VPN_W - BIG_OFF_W;

  logic               s_hit, b_hit;
  logic [VPN_W-1:0]   s_pfn;
  logic [B_PFN_W-1:0] b_pfn;
  attr_t              s_attr, b_attr;

  tlb_array #(.SETS(SMALL_SETS), .TAG_W(S_TAG_W), .PFN_W(VPN_W)) u_small (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lkp_i       (lkp_valid_i),
    .lkp_set_i   (lkp_vpn_i[S_SET_W-1:0]),
    .lkp_tag_i   (lkp_vpn_i[VPN_W-1:S_SET_W]),
    .hit_o       (s_hit),
    .hit_pfn_o   (s_pfn),
    .hit_attr_o  (s_attr),
    .fill_i      (fill_valid_i && !fill_big_i),
    .fill_set_i  (fill_vpn_i[S_SET_W-1:0]),
    .fill_tag_i  (fill_vpn_i[VPN_W-1:S_SET_W]),
    .fill_pfn_i  (fill_pfn_i),
    .fill_attr_i (fill_attr_i),
    .flush_all_i (flush_all_i),
    .flush_ng_i  (flush_ng_i)
  );

  tlb_array #(.SETS(BIG_SETS), .TAG_W(B_TAG_W), .PFN_W(B_PFN_W)) u_big (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lkp_i       (lkp_valid_i && !s_hit),
    .lkp_set_i   (lkp_vpn_i[BIG_OFF_W+B_SET_W-1:BIG_OFF_W]),
    .lkp_tag_i   (lkp_vpn_i[VPN_W-1:BIG_OFF_W+B_SET_W]),
    .hit_o       (b_hit),
    .hit_pfn_o   (b_pfn),
    .hit_attr_o  (b_attr),
    .fill_i      (fill_valid_i && fill_big_i),
    .fill_set_i  (fill_vpn_i[BIG_OFF_W+B_SET_W-1:BIG_OFF_W]),
    .fill_tag_i  (fill_vpn_i[VPN_W-1:BIG_OFF_W+B_SET_W]),
    .fill_pfn_i  (fill_pfn_i[VPN_W-1:BIG_OFF_W]),
    .fill_attr_i (fill_attr_i),
    .flush_all_i (flush_all_i),
    .flush_ng_i  (flush_ng_i)
  );

  always_comb begin
    lkp_hit_o  = lkp_valid_i && (s_hit || b_hit);
    lkp_big_o  = 1'b0;
    lkp_pfn_o  = '0;
    lkp_attr_o = '0;
    if (lkp_valid_i && s_hit) begin
      lkp_pfn_o  = s_pfn;
      lkp_attr_o = s_attr;
    end else if (lkp_valid_i && b_hit) begin
      lkp_big_o  = 1'b1;
      lkp_pfn_o  = {b_pfn, lkp_vpn_i[BIG_OFF_W-1:0]};
      lkp_attr_o = b_attr;
    end
  end
endmodule

// File: tb/sim_dual_tlb.sv
`timescale 1ns/1ps
module sim_dual_tlb;
  logic        clk = 0;
  logic        rst_ni = 0;
  logic        lkp_valid = 0;
  logic [19:0] lkp_vpn = '0;
  logic        lkp_hit_o, lkp_big_o;
  logic [19:0] lkp_pfn_o;
  logic [5:0]  lkp_attr_o;
  logic        fill_valid = 0, fill_big = 0;
  logic [19:0] fill_vpn = '0, fill_pfn = '0;
  logic [5:0]  fill_attr = '0;
  logic        flush_all = 0, flush_ng = 0;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dual_tlb u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .lkp_valid_i(lkp_valid), .lkp_vpn_i(lkp_vpn),
    .lkp_hit_o(lkp_hit_o), .lkp_big_o(lkp_big_o),
    .lkp_pfn_o(lkp_pfn_o), .lkp_attr_o(lkp_attr_o),
    .fill_valid_i(fill_valid), .fill_big_i(fill_big),
    .fill_vpn_i(fill_vpn), .fill_pfn_i(fill_pfn), .fill_attr_i(fill_attr),
    .flush_all_i(flush_all), .flush_ng_i(flush_ng)
  );

  task automatic look(input logic [19:0] v, input bit eh, input logic [19:0] ep,
                      input logic [5:0] ea, input bit eb, input string req);
    logic [27:0] act, exp;
    @(negedge clk);
    lkp_valid = 1; lkp_vpn = v;
    #1;
    n_chk++;
    act = {lkp_hit_o, lkp_big_o, lkp_attr_o, lkp_pfn_o};
    exp = eh ? {1'b1, eb, ea, ep} : 28'h0;
    if (eh ? (act != exp) : lkp_hit_o) begin
      n_bad++;
      $display("FAIL %s vpn=%h act={hit,big,attr,pfn}=%h exp=%h", req, v, act, exp);
    end
    @(posedge clk); #1;
    lkp_valid = 0;
  endtask

  task automatic pulse(input bit fa, input bit fn, input bit fv, input bit fb,
                       input logic [19:0] v, input logic [19:0] p, input logic [5:0] a);
    @(negedge clk);
    flush_all = fa; flush_ng = fn;
    fill_valid = fv; fill_big = fb; fill_vpn = v; fill_pfn = p; fill_attr = a;
    @(posedge clk); #1;
    flush_all = 0; flush_ng = 0; fill_valid = 0;
  endtask

  task automatic fill(input bit fb, input logic [19:0] v, input logic [19:0] p, input logic [5:0] a);
    pulse(0, 0, 1, fb, v, p, a);
  endtask

  task automatic flush_everything();
    pulse(1, 0, 0, 0, '0, '0, '0);
  endtask

  function automatic logic [19:0] s_vpn(int s, int w);
    return {16'(w * 37 + s + 1), 4'(s)};
  endfunction
  function automatic logic [19:0] b_vpn(int s, int w, int lo);
    return {9'(w * 5 + s + 3), 1'(s), 10'(lo)};
  endfunction
  function automatic logic [9:0] b_hi(int s, int w);
    return 10'(w * 41 + s * 7 + 100);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;

    // R1 reset state
    look(20'h00011, 0, '0, '0, 0, "R1");
    look(20'h81C05, 0, '0, '0, 0, "R1");

    // R2 R5 fill all small entries, then look them all up
    for (int s = 0; s < 16; s++)
      for (int w = 0; w < 4; w++)
        fill(0, s_vpn(s, w), s_vpn(s, w) ^ 20'h5A5A5, 6'(s * 4 + w));
    // R3 R5 fill all large entries; low pfn bits given as ones must be ignored
    for (int s = 0; s < 2; s++)
      for (int w = 0; w < 4; w++)
        fill(1, b_vpn(s, w, 0), {b_hi(s, w), 10'h3FF}, 6'(w + s * 8 + 32));
    for (int s = 0; s < 16; s++)
      for (int w = 0; w < 4; w++)
        look(s_vpn(s, w), 1, s_vpn(s, w) ^ 20'h5A5A5, 6'(s * 4 + w), 0, "R2_R5");
    for (int s = 0; s < 2; s++)
      for (int w = 0; w < 4; w++)
        look(b_vpn(s, w, w * 97 + s * 13), 1, {b_hi(s, w), 10'(w * 97 + s * 13)},
             6'(w + s * 8 + 32), 1, "R3_R5");
    look({16'hFFFF, 4'h3}, 0, '0, '0, 0, "R2");

    // R4 small page inside a mapped large page wins
    fill(0, b_vpn(0, 0, 5), 20'hCAFE0, 6'h0A);
    look(b_vpn(0, 0, 5), 1, 20'hCAFE0, 6'h0A, 0, "R4");
    look(b_vpn(0, 0, 6), 1, {b_hi(0, 0), 10'd6}, 6'd32, 1, "R4");

    // R9 flush-all
    flush_everything();
    for (int s = 0; s < 16; s++)
      for (int w = 0; w < 4; w++)
        look(s_vpn(s, w), 0, '0, '0, 0, "R9");
    for (int s = 0; s < 2; s++)
      for (int w = 0; w < 4; w++)
        look(b_vpn(s, w, 1), 0, '0, '0, 0, "R9");

    // R6 empty ways first, then oldest fill evicted
    for (int s = 0; s < 16; s++) begin
      for (int k = 0; k < 5; k++)
        fill(0, {16'(16'h1000 + k * 16 + s), 4'(s)}, {16'(16'h1000 + k * 16 + s), 4'(s)} ^ 20'h0F0F0, 6'(k));
      look({16'(16'h1000 + s), 4'(s)}, 0, '0, '0, 0, "R6");
      for (int k = 1; k < 5; k++)
        look({16'(16'h1000 + k * 16 + s), 4'(s)}, 1,
             {16'(16'h1000 + k * 16 + s), 4'(s)} ^ 20'h0F0F0, 6'(k), 0, "R6");
    end
    for (int s = 0; s < 2; s++) begin
      for (int k = 0; k < 5; k++)
        fill(1, {9'(100 + k), 1'(s), 10'h0}, {10'(200 + k), 10'h0}, 6'(k));
      look({9'd100, 1'(s), 10'h0}, 0, '0, '0, 0, "R6");
      for (int k = 1; k < 5; k++)
        look({9'(100 + k), 1'(s), 10'(k)}, 1, {10'(200 + k), 10'(k)}, 6'(k), 1, "R6");
    end

    // R7 a lookup hit protects its way
    flush_everything();
    for (int k = 0; k < 4; k++)
      fill(0, {16'(16'h3000 + k), 4'd3}, 20'(k + 16'h700), 6'(k));
    look({16'h3000, 4'd3}, 1, 20'h00700, 6'd0, 0, "R7");
    fill(0, {16'h3004, 4'd3}, 20'h00704, 6'd4);
    look({16'h3002, 4'd3}, 0, '0, '0, 0, "R7");
    look({16'h3000, 4'd3}, 1, 20'h00700, 6'd0, 0, "R7");
    look({16'h3001, 4'd3}, 1, 20'h00701, 6'd1, 0, "R7");
    look({16'h3003, 4'd3}, 1, 20'h00703, 6'd3, 0, "R7");
    look({16'h3004, 4'd3}, 1, 20'h00704, 6'd4, 0, "R7");

    // R8 refill of same tag overwrites
    flush_everything();
    fill(0, 20'h4567A, 20'h11111, 6'h03);
    fill(0, 20'h4567A, 20'h22222, 6'h04);
    look(20'h4567A, 1, 20'h22222, 6'h04, 0, "R8");
    fill(1, {9'h1AB, 1'b1, 10'h0}, {10'h111, 10'h0}, 6'h01);
    fill(1, {9'h1AB, 1'b1, 10'h0}, {10'h222, 10'h0}, 6'h02);
    look({9'h1AB, 1'b1, 10'h155}, 1, {10'h222, 10'h155}, 6'h02, 1, "R8");

    // R10 non-global flush keeps global entries
    flush_everything();
    for (int k = 0; k < 4; k++)
      fill(0, {16'(16'h2000 + k), 4'd5}, 20'(16'h900 + k), (k < 2) ? 6'(6'h20 | k) : 6'(k));
    fill(1, {9'h050, 1'b1, 10'h0}, {10'h050, 10'h0}, 6'h21);
    fill(1, {9'h051, 1'b1, 10'h0}, {10'h051, 10'h0}, 6'h01);
    pulse(0, 1, 0, 0, '0, '0, '0);
    for (int k = 0; k < 4; k++)
      look({16'(16'h2000 + k), 4'd5}, k < 2, 20'(16'h900 + k), 6'(6'h20 | k), 0, "R10");
    look({9'h050, 1'b1, 10'h7}, 1, {10'h050, 10'h7}, 6'h21, 1, "R10");
    look({9'h051, 1'b1, 10'h7}, 0, '0, '0, 0, "R10");

    // R11 flush and fill in the same cycle
    flush_everything();
    fill(0, 20'h0ABC1, 20'h0AAAA, 6'h02);
    pulse(1, 0, 1, 0, 20'h0DEF2, 20'h0BBBB, 6'h03);
    look(20'h0ABC1, 0, '0, '0, 0, "R11");
    look(20'h0DEF2, 1, 20'h0BBBB, 6'h03, 0, "R11");
    fill(0, 20'h0F0F3, 20'h0CCCC, 6'h01);
    pulse(0, 1, 1, 1, {9'h0C3, 1'b0, 10'h0}, {10'h0C3, 10'h0}, 6'h05);
    look(20'h0F0F3, 0, '0, '0, 0, "R11");
    look({9'h0C3, 1'b0, 10'h2A}, 1, {10'h0C3, 10'h2A}, 6'h05, 1, "R11");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule